// File: doc/BRIEF.md
# Bit-Reverse and Circular Pointer Update Unit

This unit rewrites a packed 32-bit addressing register after a memory access made in one of two buffer-walking modes used by signal-processing code. The low half of the register is always an index into the buffer. The high half is passed through untouched. In the bit-reverse mode the high half is the step and the index advances with a carry that travels from the most significant bit downwards, which is the visiting order an FFT wants. In the circular mode the high half is the buffer size. The index moves by a signed offset taken from the instruction word and is then wrapped back into the buffer.

A request is made with a one-cycle `start_i` pulse that carries the mode, the register value and the instruction word. The bit-reverse update, the wrap of a negative sum and the zero-length case all finish on the next cycle. A non-negative circular sum goes to a restoring remainder engine that handles one dividend bit per cycle. The new register value is shown on `reg_out` with a one-cycle `done_o` pulse, and `reg_out` keeps that value until the next result.

Top module: `ptr_update_unit`

## Requirements
- R1: With `mode_i` = 0 (bit-reverse), the index is `reg_in[15:0]` and the step is `reg_in[31:16]`. The new index is mirror(mirror(index) + mirror(step)). The sum is truncated to 16 bits and its carry is dropped.
- R2: mirror() moves every bit i of a 16-bit value to bit 15-i.
- R3: In every mode and in every case, `reg_out[31:16]` of a result equals `reg_in[31:16]` of the request that produced it.
- R4: The circular offset is 10 bits wide. Its bits 5:0 are `insn_i[21:16]` and its bits 9:6 are `insn_i[31:28]`. It is sign-extended from bit 9. No other instruction bit has any effect on the result.
- R5: With `mode_i` = 1 (circular), the index is `reg_in[15:0]` and the length is `reg_in[31:16]`. When index + offset is zero or more and the length is not zero, the new index is (index + offset) modulo length.
- R6: A bit-reverse request raises `done_o` in the cycle right after the cycle in which `start_i` was high.
- R7: When the signed sum index + offset is negative and the length is not zero, the new index is (sum + length) truncated to 16 bits, and `done_o` rises one cycle after start.
- R8: A circular request with length zero returns `reg_in` unchanged, with `err_o` = 1 and `done_o` one cycle after start. Every other result has `err_o` = 0.
- R9: A circular request with a non-negative sum and a non-zero length raises `done_o` exactly 18 cycles after the start cycle (17 remainder steps).
- R10: A `start_i` that arrives while a remainder is in progress is ignored. It produces no result and does not change the result in progress.
- R11: After reset, `done_o` = 0, `err_o` = 0 and `reg_out` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle request strobe |
| mode_i | input | 1 | 0 = bit-reverse update, 1 = circular update |
| reg_in | input | 32 | Packed addressing register: index in the low half, step or length in the high half |
| insn_i | input | 32 | Instruction word that holds the split offset field |
| reg_out | output | 32 | Updated addressing register, held until the next result |
| done_o | output | 1 | One-cycle pulse marking a new `reg_out` |
| err_o | output | 1 | Set with a result whose circular length was zero |

## Verification
The bench sets up an index and a step whose mirrored sum overflows. A unit that kept the carry, or that added without mirroring, would return a non-zero index where zero is expected. It walks the offset through -1, -512 and +511, and sets every instruction bit outside the offset field. A wrong split or a missing sign extension would therefore show up as a wrong remainder, or as a wrap that takes the wrong branch. A length too small to bring a negative sum back into range is tested, and the result must be the truncated sum. The maximum index with the maximum length is also tested, which exercises the seventeenth dividend bit that a 16-step divider would lose. A stray start during a division must neither corrupt the running remainder nor produce a second `done_o`. A zero length must come back untouched and flagged, and not hang the divider.

// File: rtl/ptr_update_pkg.sv
package ptr_update_pkg;
   typedef enum logic {
      PTR_MODE_BITREV = 1'b0,
      PTR_MODE_CIRC   = 1'b1
   } ptr_mode_e;
endpackage

// File: rtl/ptr_mirror.sv
module ptr_mirror #(
   parameter int W = 16
) (
   input  logic [W-1:0] val_i,
   output logic [W-1:0] val_o
);
   for (genvar i = 0; i < W; i++) begin : g_bit
      assign val_o[i] = val_i[W-1-i];
   end
endmodule

// File: rtl/ptr_bitrev_step.sv
module ptr_bitrev_step #(
   parameter int W = 16
) (
   input  logic [W-1:0] idx_i,
   input  logic [W-1:0] step_i,
   output logic [W-1:0] idx_o
);
   logic [W-1:0] idx_m, step_m, sum_m;

   ptr_mirror #(.W(W)) u_mir_idx  (.val_i(idx_i),  .val_o(idx_m));
   ptr_mirror #(.W(W)) u_mir_step (.val_i(step_i), .val_o(step_m));

   // carry out of the mirrored add is dropped by the width of sum_m
   assign sum_m = idx_m + step_m;

   ptr_mirror #(.W(W)) u_mir_out  (.val_i(sum_m),  .val_o(idx_o));
endmodule

// File: rtl/ptr_off_decode.sv
module ptr_off_decode #(
   parameter int INSN_W = 32,
   parameter int LO_POS = 16,
   parameter int LO_W   = 6,
   parameter int HI_POS = 28,
   parameter int HI_W   = 4,
   parameter int OUT_W  = 18
) (
   input  logic [INSN_W-1:0] insn_i,
   output logic [OUT_W-1:0]  off_o
);
   localparam int OFF_W = LO_W + HI_W;

   logic [OFF_W-1:0] off_raw;

   if (HI_W == 0) begin : g_single
      assign off_raw = insn_i[LO_POS +: LO_W];
   end else begin : g_split
      assign off_raw = {insn_i[HI_POS +: HI_W], insn_i[LO_POS +: LO_W]};
   end

   assign off_o = {{(OUT_W-OFF_W){off_raw[OFF_W-1]}}, off_raw};
endmodule

// File: rtl/ptr_rem_seq.sv
module ptr_rem_seq #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load_i,
   input  logic [W:0]   dividend_i,
   input  logic [W-1:0] divisor_i,
   output logic         busy_o,
   output logic         last_o,
   output logic [W-1:0] rem_o
);
   localparam int STEPS = W + 1;
   localparam int CNT_W = $clog2(STEPS + 1);

   logic [W-1:0]     rem_q, div_q, rem_nxt;
   logic [W:0]       dvd_q, trial, diff;
   logic [CNT_W-1:0] cnt_q;
   logic             take;

   // restoring step: bring down the next dividend bit, subtract when it fits
   always_comb begin
      trial   = {rem_q, dvd_q[W]};
      diff    = trial - {1'b0, div_q};
      take    = (trial >= {1'b0, div_q});
      rem_nxt = take ? diff[W-1:0] : trial[W-1:0];
   end

   assign busy_o = (cnt_q != '0);
   assign last_o = (cnt_q == CNT_W'(1));
   assign rem_o  = rem_nxt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rem_q <= '0;
         div_q <= '0;
         dvd_q <= '0;
         cnt_q <= '0;
      end else if (load_i) begin
         rem_q <= '0;
         div_q <= divisor_i;
         dvd_q <= dividend_i;
         cnt_q <= CNT_W'(STEPS);
      end else if (busy_o) begin
         rem_q <= rem_nxt;
         dvd_q <= {dvd_q[W-1:0], 1'b0};
         cnt_q <= cnt_q - CNT_W'(1);
      end
   end
endmodule

// File: rtl/ptr_update_unit.sv
module ptr_update_unit
   import ptr_update_pkg::*;
#(
   parameter int HALF_W     = 16,
   parameter int INSN_W     = 32,
   parameter int OFF_LO_POS = 16,
   parameter int OFF_LO_W   = 6,
   parameter int OFF_HI_POS = 28,
   parameter int OFF_HI_W   = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start_i,
   input  logic                mode_i,
   input  logic [2*HALF_W-1:0] reg_in,
   input  logic [INSN_W-1:0]   insn_i,
   output logic [2*HALF_W-1:0] reg_out,
   output logic                done_o,
   output logic                err_o
);
   localparam int REG_W = 2 * HALF_W;
   localparam int OFF_W = OFF_LO_W + OFF_HI_W;
   localparam int SUM_W = HALF_W + 2;

   if (HALF_W < 2) begin : g_chk_half
      $error("HALF_W must be at least 2");
   end
   if (OFF_W >= HALF_W) begin : g_chk_off
      $error("offset field must be narrower than the index");
   end
   if (OFF_LO_POS + OFF_LO_W > INSN_W || OFF_HI_POS + OFF_HI_W > INSN_W) begin : g_chk_pos
      $error("offset field lies outside the instruction word");
   end

   ptr_mode_e         mode;
   logic [HALF_W-1:0] idx, hi, br_idx, rem_val, wrap_idx;
   logic [SUM_W-1:0]  off_ext, sum;
   logic              sum_neg, len_zero, accept, div_load, busy, div_last;

   logic [REG_W-1:0]  reg_q;
   logic [HALF_W-1:0] hi_q;
   logic              done_q, err_q;

   assign mode     = ptr_mode_e'(mode_i);
   assign idx      = reg_in[HALF_W-1:0];
   assign hi       = reg_in[REG_W-1:HALF_W];
   assign accept   = start_i && !busy;

   ptr_bitrev_step #(.W(HALF_W)) u_bitrev (
      .idx_i  (idx),
      .step_i (hi),
      .idx_o  (br_idx)
   );

   ptr_off_decode #(
      .INSN_W (INSN_W),
      .LO_POS (OFF_LO_POS),
      .LO_W   (OFF_LO_W),
      .HI_POS (OFF_HI_POS),
      .HI_W   (OFF_HI_W),
      .OUT_W  (SUM_W)
   ) u_off (
      .insn_i (insn_i),
      .off_o  (off_ext)
   );

   always_comb begin
      sum      = {2'b00, idx} + off_ext;
      sum_neg  = sum[SUM_W-1];
      len_zero = (hi == '0);
      wrap_idx = sum[HALF_W-1:0] + hi;
      div_load = accept && (mode == PTR_MODE_CIRC) && !len_zero && !sum_neg;
   end

   ptr_rem_seq #(.W(HALF_W)) u_rem (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (div_load),
      .dividend_i (sum[HALF_W:0]),
      .divisor_i  (hi),
      .busy_o     (busy),
      .last_o     (div_last),
      .rem_o      (rem_val)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         reg_q  <= '0;
         hi_q   <= '0;
         done_q <= 1'b0;
         err_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (accept) begin
            hi_q <= hi;
            if (mode == PTR_MODE_BITREV) begin
               reg_q  <= {hi, br_idx};
               err_q  <= 1'b0;
               done_q <= 1'b1;
            end else if (len_zero) begin
               reg_q  <= reg_in;
               err_q  <= 1'b1;
               done_q <= 1'b1;
            end else if (sum_neg) begin
               reg_q  <= {hi, wrap_idx};
               err_q  <= 1'b0;
               done_q <= 1'b1;
            end
         end else if (div_last) begin
            reg_q  <= {hi_q, rem_val};
            err_q  <= 1'b0;
            done_q <= 1'b1;
         end
      end
   end

   assign reg_out = reg_q;
   assign done_o  = done_q;
   assign err_o   = err_q;
endmodule

// File: rtl/ptr_update_chk.sv
module ptr_update_chk #(
   parameter int HALF_W = 16
) (
   input logic                clk,
   input logic                rst_n,
   input logic                start_i,
   input logic                mode_i,
   input logic [2*HALF_W-1:0] reg_in,
   input logic                busy,
   input logic [2*HALF_W-1:0] reg_out,
   input logic                done_o,
   input logic                err_o
);
   localparam int STEPS = HALF_W + 1;
   localparam int RUN_W = $clog2(STEPS + 2) + 1;

   logic [HALF_W-1:0] hi_seen;
   logic [RUN_W-1:0]  busy_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_seen  <= '0;
         busy_run <= '0;
      end else begin
         if (start_i && !busy) hi_seen <= reg_in[2*HALF_W-1:HALF_W];
         busy_run <= busy ? busy_run + RUN_W'(1) : '0;
      end
   end

   assert_bitrev_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !busy && !mode_i) |=> done_o);

   assert_zero_len_pass_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !busy && mode_i && reg_in[2*HALF_W-1:HALF_W] == '0)
      |=> (done_o && err_o && reg_out == $past(reg_in)));

   assert_err_needs_zero_len_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && err_o) |-> (hi_seen == '0));

   assert_upper_keep_R3: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (reg_out[2*HALF_W-1:HALF_W] == hi_seen));

   assert_div_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
      busy_run <= RUN_W'(STEPS));

   assert_no_done_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !done_o);
endmodule

bind ptr_update_unit ptr_update_chk #(.HALF_W(HALF_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .start_i (start_i),
   .mode_i  (mode_i),
   .reg_in  (reg_in),
   .busy    (busy),
   .reg_out (reg_out),
   .done_o  (done_o),
   .err_o   (err_o)
);

// File: tb/tb_ptr_update_unit.sv
module tb_ptr_update_unit;
   localparam int CLK_PERIOD = 10;

   typedef struct {
      logic [31:0] r;
      logic        e;
      int          lat;
      int          t0;
      string       tag;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic        mode_i = 1'b0;
   logic [31:0] reg_in = '0;
   logic [31:0] insn_i = '0;
   logic [31:0] reg_out;
   logic        done_o, err_o;

   int   checks = 0;
   int   fails = 0;
   int   cyc = 0;
   exp_t q[$];

   ptr_update_unit dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
      .reg_in(reg_in), .insn_i(insn_i), .reg_out(reg_out),
      .done_o(done_o), .err_o(err_o)
   );

   always #(CLK_PERIOD/2) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   function automatic logic [15:0] mirror16(input logic [15:0] v);
      logic [15:0] r;
      for (int i = 0; i < 16; i++) r[i] = v[15-i];
      return r;
   endfunction

   task automatic check(input string tag, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   // monitor: pop one expected item for every done pulse
   always @(negedge clk) begin
      if (rst_n && done_o) begin
         if (q.size() == 0) begin
            check("R10 unexpected done", 1, 0);
         end else begin
            exp_t x;
            x = q.pop_front();
            check({x.tag, " value"}, reg_out, x.r);
            check({x.tag, " err"}, err_o, x.e);
            check({x.tag, " latency"}, cyc - x.t0, x.lat);
         end
      end
   end

   task automatic issue(input logic m, input logic [31:0] r, input logic [31:0] ins,
                        input string tag, input int stray_at = 0);
      exp_t x;
      logic [15:0] idx, hi;
      int off, sum;
      idx = r[15:0];
      hi  = r[31:16];
      x.tag = tag;
      x.e = 1'b0;
      if (!m) begin
         x.r = {hi, mirror16(mirror16(idx) + mirror16(hi))};
         x.lat = 1;
      end else begin
         off = {ins[31:28], ins[21:16]};
         if (off >= 512) off -= 1024;
         sum = int'(idx) + off;
         if (hi == 0) begin
            x.r = r; x.e = 1'b1; x.lat = 1;
         end else if (sum < 0) begin
            x.r = {hi, 16'(sum + int'(hi))}; x.lat = 1;
         end else begin
            x.r = {hi, 16'(sum % int'(hi))}; x.lat = 18;
         end
      end
      @(negedge clk);
      x.t0 = cyc;
      q.push_back(x);
      start_i = 1'b1; mode_i = m; reg_in = r; insn_i = ins;
      @(negedge clk);
      start_i = 1'b0;
      if (stray_at > 0) begin
         repeat (stray_at) @(negedge clk);
         start_i = 1'b1; mode_i = 1'b0; reg_in = 32'h1234_5678; insn_i = '1;
         @(negedge clk);
         start_i = 1'b0;
      end
      while (q.size() != 0) @(negedge clk);
      @(negedge clk);
   endtask

   function automatic logic [31:0] off_insn(input int off, input logic [31:0] junk);
      logic [9:0] o;
      logic [31:0] w;
      o = 10'(off);
      w = junk;
      w[21:16] = o[5:0];
      w[31:28] = o[9:6];
      return w;
   endfunction

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R11 reset state
      check("R11 done", done_o, 0);
      check("R11 err", err_o, 0);
      check("R11 reg", reg_out, 0);
      rst_n = 1'b1;
      @(negedge clk);

      issue(1'b0, 32'h0001_0000, '0, "R1 R2 zero index");
      issue(1'b0, 32'h0001_0001, '0, "R1 carry dropped");
      issue(1'b0, 32'h0004_0006, '0, "R2 R6 mirror step");
      issue(1'b0, 32'hFFFF_FFFF, '0, "R1 R3 all ones");
      for (int i = 0; i < 12; i++)
         issue(1'b0, $urandom, $urandom, "R1 R6 random");

      issue(1'b1, 32'h0010_000A, off_insn(9, '0), "R5 R9 forward wrap");
      issue(1'b1, 32'h0008_0000, off_insn(-1, '0), "R7 minus one");
      issue(1'b1, 32'h0064_0005, off_insn(-512, '0), "R7 short length truncation");
      issue(1'b1, 32'hFFFF_FFFF, off_insn(511, '0), "R5 R9 top dividend bit");
      issue(1'b1, 32'h0003_FFFF, off_insn(0, '0), "R5 small length");
      issue(1'b1, 32'h0100_0020, off_insn(-5, 32'h0FC0_FFFF), "R4 junk bits ignored");
      issue(1'b1, 32'h0100_0020, off_insn(200, 32'h0FC0_FFFF), "R4 R5 positive junk");
      issue(1'b1, 32'h0000_1234, off_insn(7, '0), "R8 zero length");
      issue(1'b1, 32'h0000_0000, off_insn(-3, '0), "R8 zero length negative");
      issue(1'b1, 32'h0123_0456, off_insn(33, '0), "R10 stray start", 4);
      repeat (25) @(negedge clk);
      for (int i = 0; i < 12; i++) begin
         logic [31:0] r;
         r = $urandom;
         if (r[31:16] == 0) r[31:16] = 16'h0101;
         issue(1'b1, r, $urandom, "R3 R5 R7 random circular");
      end

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule